// File: doc/BRIEF.md
# Ramp ADC Counter Back-End with Common-Mode Start Delay

This block is the digital side of a multi-channel single-slope (ramp) converter. All channels share one counter. After a ramp-reset strobe arms the channels and a counter-reset strobe starts a conversion, the counter steps once per clock. Each channel has a comparator flag. On the selected transition of that flag, the channel captures the counter value as its code. The counter stops at a programmable ceiling. Any channel that has not triggered by then takes the ceiling value, and a done flag follows one cycle later.

In the delayed-start mode, the counter is held at zero after the counter-reset. It stays there until a programmed number of channels have captured. Channels that sit at the common baseline trigger first and read zero, so the shared offset is removed from every code. The clock is meant to run at twice the converter's reference rate, so counting once per cycle gives the same resolution as counting on both edges of the slower clock.

Top module: `wadc_backend`

## Requirements
- R1: After the asynchronous reset, every code is 0 and `done_o` is low.
- R2: With `dps_en_i`=0, the counter-reset strobe sampled at edge E0 loads 0 into the counter, and the counter then adds one at every later edge. A channel whose trigger arrives between edge Ek and E(k+1) gets code k. Channel c is found at `code_o[c*CNT_W +: CNT_W]`.
- R3: The counter stops at `modulo_i`. When it gets there, every channel that has not yet triggered captures the `modulo_i` value. With `modulo_i`=0, every code is 0.
- R4: `done_o` goes high one cycle after the counter equals `modulo_i`. It stays high until the next ramp-reset or counter-reset.
- R5: With `dps_en_i`=1, the counter stays at 0 after the counter-reset. It stays there until the number of captured channels is at least `fire_thr_i`. The hold ends on the next edge, and counting starts on the edge after that. Channels that capture during the hold read 0. With a threshold of 0, the start is one cycle late. If the threshold is never reached, `done_o` never rises.
- R6: With `cmp_pol_i`=0, a channel triggers on a 0-to-1 change of its comparator flag. With `cmp_pol_i`=1, it triggers on a 1-to-0 change. A change in the other direction has no effect.
- R7: Each channel captures at most once per conversion. Later comparator changes are ignored, and the codes do not change while `done_o` is high.
- R8: A ramp-reset strobe clears all codes and `done_o`, re-arms all channels and returns the counter to idle. It overrides a counter-reset strobe in the same cycle. With no counter-reset after it, `done_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counting clock (twice the reference rate) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ramp_rst_i | input | 1 | Ramp-reset strobe: clears and arms the channels |
| cnt_rst_i | input | 1 | Counter-reset strobe: starts a conversion |
| dps_en_i | input | 1 | Delayed-start (common-mode removal) mode |
| cmp_pol_i | input | 1 | Trigger sense: 0 rising, 1 falling |
| modulo_i | input | CNT_W | Counter ceiling |
| fire_thr_i | input | $clog2(NUM_CH+1) | Captured-channel count that releases the counter |
| cmp_i | input | NUM_CH | Comparator flags, one per channel |
| code_o | output | NUM_CH*CNT_W | Captured codes, channel c at bits c*CNT_W |
| done_o | output | 1 | Conversion finished |

## Verification
The bench builds the block with 8 channels and an 8-bit counter. With only 8 channels, the release threshold can be set to every channel, so the population count can reach its full value. Each channel's trigger time can also be placed on any cycle, including before, during and after the counter's release. Ceilings of 0, 5 and 30 keep whole conversions short. This covers both trigger senses, the saturation sweep and a threshold that is never reached.

// File: rtl/wadc_pkg.sv
package wadc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HOLD = 2'd1,
    PH_RUN  = 2'd2,
    PH_DONE = 2'd3
  } phase_e;
endpackage

// File: rtl/wadc_popcount.sv
module wadc_popcount #(
  parameter int N = 128,
  parameter int W = $clog2(N + 1)
) (
  input  logic [N-1:0] bits_i,
  output logic [W-1:0] count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < N; i++) begin
      count_o = count_o + W'(bits_i[i]);
    end
  end
endmodule

// File: rtl/wadc_cnt_ctrl.sv
module wadc_cnt_ctrl
  import wadc_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int FC_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ramp_rst_i,
  input  logic             cnt_rst_i,
  input  logic             dps_en_i,
  input  logic [CNT_W-1:0] modulo_i,
  input  logic [FC_W-1:0]  fire_thr_i,
  input  logic [FC_W-1:0]  fired_cnt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             hold_o,
  output logic             sat_o,
  output logic             done_o
);
  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               at_top;

  assign at_top = (cnt_q >= modulo_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (ramp_rst_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (cnt_rst_i) begin
      phase_q <= dps_en_i ? PH_HOLD : PH_RUN;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_HOLD: if (fired_cnt_i >= fire_thr_i) phase_q <= PH_RUN;
        PH_RUN: begin
          if (at_top) phase_q <= PH_DONE;
          else        cnt_q   <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign cnt_o  = cnt_q;
  assign run_o  = (phase_q == PH_RUN);
  assign hold_o = (phase_q == PH_HOLD);
  assign sat_o  = run_o && at_top;
  assign done_o = (phase_q == PH_DONE);
endmodule

// File: rtl/wadc_chan.sv
module wadc_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             sat_i,
  input  logic             pol_i,
  input  logic             cmp_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] code_o,
  output logic             got_o
);
  logic cmp_q;
  logic trig;

  // pol_i=0 rising, pol_i=1 falling
  assign trig = pol_i ? (cmp_q & ~cmp_i) : (~cmp_q & cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmp_q <= 1'b0;
    else         cmp_q <= cmp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= '0;
      got_o  <= 1'b0;
    end else if (clr_i) begin
      code_o <= '0;
      got_o  <= 1'b0;
    end else if (!got_o && (sat_i || (en_i && trig))) begin
      code_o <= cnt_i;
      got_o  <= 1'b1;
    end
  end
endmodule

// File: rtl/wadc_backend.sv
module wadc_backend #(
  parameter int NUM_CH = 128,
  parameter int CNT_W  = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       ramp_rst_i,
  input  logic                       cnt_rst_i,
  input  logic                       dps_en_i,
  input  logic                       cmp_pol_i,
  input  logic [CNT_W-1:0]           modulo_i,
  input  logic [$clog2(NUM_CH+1)-1:0] fire_thr_i,
  input  logic [NUM_CH-1:0]          cmp_i,
  output logic [NUM_CH*CNT_W-1:0]    code_o,
  output logic                       done_o
);
  localparam int FC_W = $clog2(NUM_CH + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic              run_q;
  logic              hold_q;
  logic              sat;
  logic [NUM_CH-1:0] got;
  logic [FC_W-1:0]   fired_cnt;
  logic              lat_en;
  logic              clr;

  // a ramp-reset also blocks capture in the cycle it is applied
  assign clr    = ramp_rst_i;
  assign lat_en = (run_q || hold_q) && !cnt_rst_i;

  wadc_cnt_ctrl #(.CNT_W(CNT_W), .FC_W(FC_W)) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ramp_rst_i  (ramp_rst_i),
    .cnt_rst_i   (cnt_rst_i),
    .dps_en_i    (dps_en_i),
    .modulo_i    (modulo_i),
    .fire_thr_i  (fire_thr_i),
    .fired_cnt_i (fired_cnt),
    .cnt_o       (cnt_q),
    .run_o       (run_q),
    .hold_o      (hold_q),
    .sat_o       (sat),
    .done_o      (done_o)
  );

  wadc_popcount #(.N(NUM_CH), .W(FC_W)) pop_i (
    .bits_i  (got),
    .count_o (fired_cnt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wadc_chan #(.CNT_W(CNT_W)) chan_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .en_i   (lat_en),
      .sat_i  (sat && !cnt_rst_i),
      .pol_i  (cmp_pol_i),
      .cmp_i  (cmp_i[c]),
      .cnt_i  (cnt_q),
      .code_o (code_o[c*CNT_W +: CNT_W]),
      .got_o  (got[c])
    );
  end
endmodule

// File: rtl/wadc_backend_chk.sv
module wadc_backend_chk #(
  parameter int NUM_CH = 128,
  parameter int CNT_W  = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    ramp_rst_i,
  input logic                    cnt_rst_i,
  input logic [CNT_W-1:0]        modulo_i,
  input logic [NUM_CH*CNT_W-1:0] code_o,
  input logic                    done_o,
  input logic [CNT_W-1:0]        cnt_q,
  input logic                    run_q,
  input logic                    hold_q
);
  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q < modulo_i && !ramp_rst_i && !cnt_rst_i) |=> cnt_q == $past(cnt_q) + 1'b1);

  // R3
  cnt_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> cnt_q <= modulo_i);

  // R4
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cnt_q == modulo_i && !ramp_rst_i && !cnt_rst_i) |=> done_o);

  // R5
  hold_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |-> cnt_q == '0);

  // R7
  code_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !ramp_rst_i) |=> $stable(code_o));

  // R8
  ramp_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_rst_i |=> (!done_o && code_o == '0));
endmodule

bind wadc_backend wadc_backend_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ramp_rst_i (ramp_rst_i),
  .cnt_rst_i  (cnt_rst_i),
  .modulo_i   (modulo_i),
  .code_o     (code_o),
  .done_o     (done_o),
  .cnt_q      (cnt_q),
  .run_q      (run_q),
  .hold_q     (hold_q)
);

// File: tb/wadc_backend_tb_top.sv
module wadc_backend_tb_top;
  localparam int N  = 8;
  localparam int W  = 8;
  localparam int FW = $clog2(N + 1);
  localparam int RUN_LEN = 48;

  typedef struct packed {
    logic       dps;
    logic       pol;
    logic [3:0] thr;
    logic [7:0] modv;
    logic [63:0] fire;  // byte c = trigger cycle of channel c, FF = never
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    {1'b0, 1'b0, 4'd0, 8'd10, 64'hFF0F0A0905030100},  // R2 R3
    {1'b0, 1'b1, 4'd0, 8'd20, 64'h12100E0C08060402},  // R6 falling
    {1'b1, 1'b0, 4'd3, 8'd12, 64'h1E04FF0805020100},  // R5
    {1'b1, 1'b0, 4'd0, 8'd5,  64'hFFFF0102FF060300},  // R5 thr 0
    {1'b1, 1'b0, 4'd8, 8'd6,  64'h0907060504030201},  // R5 all channels
    {1'b0, 1'b0, 4'd0, 8'd0,  64'hFFFFFFFFFFFF0500},  // R3 modulo 0
    {1'b0, 1'b0, 4'd0, 8'd30, 64'hFFFFFFFFFFFFFFFF}   // R3 no triggers
  };

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            ramp_rst = 1'b0;
  logic            cnt_rst = 1'b0;
  logic            dps_en = 1'b0;
  logic            cmp_pol = 1'b0;
  logic [W-1:0]    modulo = '0;
  logic [FW-1:0]   fire_thr = '0;
  logic [N-1:0]    cmp = '0;
  logic [N*W-1:0]  code;
  logic            done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  wadc_backend #(.NUM_CH(N), .CNT_W(W)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .ramp_rst_i (ramp_rst),
    .cnt_rst_i  (cnt_rst),
    .dps_en_i   (dps_en),
    .cmp_pol_i  (cmp_pol),
    .modulo_i   (modulo),
    .fire_thr_i (fire_thr),
    .cmp_i      (cmp),
    .code_o     (code),
    .done_o     (done)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int start_edge(vec_t v);
    if (!v.dps) return 0;
    if (v.thr == 0) return 1;
    for (int t = 0; t < 255; t++) begin
      int n = 0;
      for (int c = 0; c < N; c++)
        if (v.fire[c*8 +: 8] != 8'hFF && int'(v.fire[c*8 +: 8]) <= t) n++;
      if (n >= int'(v.thr)) return t + 2;
    end
    return 10000;
  endfunction

  function automatic int exp_code(vec_t v, int c, int s);
    int f = int'(v.fire[c*8 +: 8]);
    int x;
    if (f == 255) return int'(v.modv);
    x = f - s;
    if (x < 0) x = 0;
    if (x > int'(v.modv)) x = int'(v.modv);
    return x;
  endfunction

  task automatic pulse_ramp();
    @(posedge clk); #1 ramp_rst = 1'b1;
    @(posedge clk); #1 ramp_rst = 1'b0;
  endtask

  task automatic apply_fires(vec_t v, int k, logic idle);
    for (int c = 0; c < N; c++)
      if (v.fire[c*8 +: 8] != 8'hFF && int'(v.fire[c*8 +: 8]) == k) cmp[c] = ~idle;
  endtask

  task automatic run_vec(vec_t v, int idx);
    int s;
    int bad;
    logic idle;
    s = start_edge(v);
    idle = v.pol;
    dps_en = v.dps; cmp_pol = v.pol; fire_thr = FW'(v.thr); modulo = v.modv;
    cmp = {N{idle}};
    pulse_ramp();
    cnt_rst = 1'b1;
    @(posedge clk); #1 cnt_rst = 1'b0;  // E0
    apply_fires(v, 0, idle);
    bad = 0;
    @(negedge clk);
    if (done !== 1'b0) bad++;
    for (int k = 1; k < RUN_LEN; k++) begin
      @(posedge clk); #1 apply_fires(v, k, idle);
      @(negedge clk);
      if (done !== (k >= s + int'(v.modv) + 1)) begin
        bad++;
        $display("vector %0d done mismatch at edge %0d", idx, k);
      end
    end
    // R4 timing and hold of done
    check(bad == 0, "R4", bad, 0);
    for (int c = 0; c < N; c++)
      // R2 R3 R5 R6
      check(code[c*W +: W] == W'(exp_code(v, c, s)), v.dps ? "R5" : (v.pol ? "R6" : "R2/R3"),
            code[c*W +: W], exp_code(v, c, s));
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk);
    // R1
    check(code == '0, "R1", code[31:0], 0);
    check(done == 1'b0, "R1", done, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R6 R7: falling edge ignored with rising sense; re-triggers ignored
    dps_en = 1'b0; cmp_pol = 1'b0; modulo = 8'd20; fire_thr = '0;
    cmp = 8'b0000_0010;
    pulse_ramp();
    cnt_rst = 1'b1;
    @(posedge clk); #1 cnt_rst = 1'b0;  // E0
    for (int k = 1; k < 26; k++) begin
      @(posedge clk); #1;
      if (k == 2) cmp[0] = 1'b1;
      if (k == 3) cmp[1] = 1'b0;
      if (k == 4) cmp[0] = 1'b0;
      if (k == 6) cmp[0] = 1'b1;
      if (k == 8) cmp[1] = 1'b1;
      if (k == 23) cmp[0] = 1'b0;
    end
    @(negedge clk);
    check(code[0 +: W] == 8'd2, "R7", code[0 +: W], 2);
    check(code[W +: W] == 8'd8, "R6", code[W +: W], 8);
    check(code[2*W +: W] == 8'd20, "R3", code[2*W +: W], 20);
    check(done == 1'b1, "R4", done, 1);

    // R8: ramp-reset beats counter-reset and clears everything
    @(posedge clk); #1 ramp_rst = 1'b1; cnt_rst = 1'b1;
    @(posedge clk); #1 ramp_rst = 1'b0; cnt_rst = 1'b0;
    @(negedge clk);
    check(code == '0, "R8", code[31:0], 0);
    check(done == 1'b0, "R8", done, 0);
    repeat (30) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R8", done, 0);

    // R5: threshold never reached, counter holds, no done
    dps_en = 1'b1; fire_thr = FW'(5); modulo = 8'd3; cmp = '0;
    pulse_ramp();
    cnt_rst = 1'b1;
    @(posedge clk); #1 cnt_rst = 1'b0;
    cmp[2] = 1'b1;
    @(posedge clk); #1 cmp[5] = 1'b1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R5", done, 0);
    check(code[2*W +: W] == 8'd0, "R5", code[2*W +: W], 0);
    check(code[4*W +: W] == 8'd0, "R5", code[4*W +: W], 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule